// File: doc/BRIEF.md
# Three-Channel LED Dimming Enable Generator

This block turns per-channel dimming commands into one enable per LED channel and applies that enable to the channel's switch request, its output-disconnect drive and its error-amplifier hold. Each of the three channels is dimmed on its own. Two mode inputs choose where the enable comes from. In direct mode the enable copies a logic-level dimming input. In ramp mode each channel compares a digital dimming level against one sawtooth counter that all channels share.

In ramp mode a polarity input sets the direction of the mapping. With rising polarity a larger level gives a longer on-time, and the full-scale code gives continuous on. With falling polarity a level of zero gives continuous on, and the on-time shrinks as the level grows. A prescaler sets the ramp period. The block takes in new levels, a new mode and a new polarity only when the ramp wraps. A change made in the middle of a period therefore never shortens or splits a pulse.

Top module: `dim_mode_sel`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, every enable, switch output and disconnect output is 0, and every amplifier-hold output is 1. The active mode after reset is direct.
- R2: In direct mode (ramp_mode_i = 0, either value of rising_i), each channel's enable takes the value of its direct_dim_i bit on the third rising clock edge after that bit changes.
- R3: The ramp is an unsigned RAMP_W-bit counter. It advances by one every prescale_i+1 clocks and wraps from all-ones to zero, so one period lasts 2^RAMP_W*(prescale_i+1) clocks.
- R4: In ramp mode with rising polarity (rising_i = 1), a channel with level L (bits [c*RAMP_W +: RAMP_W] of level_i) is enabled for L ramp steps per period. L = all-ones gives continuous enable, with no low cycle at the wrap.
- R5: In ramp mode with falling polarity (rising_i = 0), a channel with level L is enabled for 2^RAMP_W-1-L ramp steps per period. L = 0 gives continuous enable.
- R6: The three channels share one ramp, and each channel's duty depends only on its own level.
- R7: A channel's level is captured only at the ramp wrap. A level change within a period leaves the rest of that period unchanged.
- R8: A change of ramp_mode_i or rising_i passes through a two-flop synchronizer and takes effect only at the next ramp wrap.
- R9: For each channel, switch_o = switch_req_i AND enable, disc_o = enable, and amp_hold_o = NOT enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ramp_mode_i | input | 1 | 0: direct dimming, 1: ramp-compare dimming |
| rising_i | input | 1 | Ramp polarity: 1 rising (full scale = full on), 0 falling (zero = full on) |
| prescale_i | input | PRE_W | Clocks per ramp step, minus one |
| direct_dim_i | input | NCH | Logic-level dimming inputs, one per channel |
| level_i | input | NCH*RAMP_W | Digital dimming levels, channel c at [c*RAMP_W +: RAMP_W] |
| switch_req_i | input | NCH | Switch-on requests from each channel's current loop |
| dim_en_o | output | NCH | Dimming enable per channel |
| switch_o | output | NCH | Gated switch drive per channel |
| disc_o | output | NCH | Output-disconnect drive per channel (1 = connected) |
| amp_hold_o | output | NCH | Error-amplifier hold per channel (1 = output floated) |

## Verification
The bench counts the enabled cycles over whole ramp periods for the levels zero, one, mid-scale, just below full scale and full scale, under both polarities and two prescale settings. These counts separate an off-by-one compare, a missing full-scale override and an inverted polarity. Each measurement gives the three channels different levels, so a shared or cross-wired level shows up. Two phase-locked runs change a level, and then the mode, a few cycles into a period. They show whether the change waits for the wrap. Direct mode is checked for its three-edge latency and for the gating of the switch, disconnect and hold outputs.

// File: rtl/dim_pkg.sv
package dim_pkg;
  typedef struct packed {
    logic ramp;    // 1: ramp-compare, 0: direct
    logic rising;  // 1: duty rises with level
  } dim_mode_t;
endpackage

// File: rtl/dim_sync2.sv
module dim_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/dim_ramp_gen.sv
module dim_ramp_gen #(
  parameter int RAMP_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  prescale_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              tick_o,
  output logic              wrap_o
);
  localparam logic [RAMP_W-1:0] RAMP_TOP = {RAMP_W{1'b1}};

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic              tick;

  always_comb begin
    tick   = (pre_q == prescale_i);
    pre_d  = tick ? '0 : pre_q + 1'b1;
    ramp_d = tick ? ramp_q + 1'b1 : ramp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ramp_q <= '0;
    end else begin
      pre_q  <= pre_d;
      ramp_q <= ramp_d;
    end
  end

  assign ramp_o = ramp_q;
  assign tick_o = tick;
  assign wrap_o = tick && (ramp_q == RAMP_TOP);
endmodule

// File: rtl/dim_chan.sv
module dim_chan
  import dim_pkg::*;
#(
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_i,
  input  logic [RAMP_W-1:0] ramp_i,
  input  logic [RAMP_W-1:0] level_i,
  input  dim_mode_t         mode_i,
  input  logic              direct_i,
  output logic              en_o,
  output logic [RAMP_W-1:0] lvl_o
);
  localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

  logic [RAMP_W-1:0] lvl_q, lvl_d;
  logic [RAMP_W-1:0] eff;
  logic              ramp_on;
  logic              en_q, en_d;

  always_comb begin
    lvl_d   = wrap_i ? level_i : lvl_q;
    eff     = mode_i.rising ? lvl_q : ~lvl_q;
    ramp_on = (eff == FULL) || (ramp_i < eff);
    en_d    = mode_i.ramp ? ramp_on : direct_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      en_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      en_q  <= en_d;
    end
  end

  assign en_o  = en_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/dim_mode_sel.sv
module dim_mode_sel
  import dim_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int RAMP_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ramp_mode_i,
  input  logic                  rising_i,
  input  logic [PRE_W-1:0]      prescale_i,
  input  logic [NCH-1:0]        direct_dim_i,
  input  logic [NCH*RAMP_W-1:0] level_i,
  input  logic [NCH-1:0]        switch_req_i,
  output logic [NCH-1:0]        dim_en_o,
  output logic [NCH-1:0]        switch_o,
  output logic [NCH-1:0]        disc_o,
  output logic [NCH-1:0]        amp_hold_o
);
  localparam int LVL_BITS = NCH * RAMP_W;

  logic [1:0]          mode_raw;
  logic [1:0]          mode_sync;
  dim_mode_t           mode_q, mode_d;
  logic [NCH-1:0]      direct_sync;
  logic [RAMP_W-1:0]   ramp;
  logic                tick;
  logic                wrap_stb;
  logic [LVL_BITS-1:0] lvl_cur;
  logic [NCH-1:0]      en;

  assign mode_raw = {ramp_mode_i, rising_i};

  dim_sync2 #(.W(2)) u_mode_sync (
    .clk(clk), .rst_n(rst_n), .d_i(mode_raw), .q_o(mode_sync)
  );

  dim_sync2 #(.W(NCH)) u_dir_sync (
    .clk(clk), .rst_n(rst_n), .d_i(direct_dim_i), .q_o(direct_sync)
  );

  dim_ramp_gen #(.RAMP_W(RAMP_W), .PRE_W(PRE_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .prescale_i(prescale_i),
    .ramp_o(ramp), .tick_o(tick), .wrap_o(wrap_stb)
  );

  always_comb begin
    mode_d = mode_q;
    if (wrap_stb) mode_d = dim_mode_t'(mode_sync);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dim_chan #(.RAMP_W(RAMP_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap_i  (wrap_stb),
      .ramp_i  (ramp),
      .level_i (level_i[c*RAMP_W +: RAMP_W]),
      .mode_i  (mode_q),
      .direct_i(direct_sync[c]),
      .en_o    (en[c]),
      .lvl_o   (lvl_cur[c*RAMP_W +: RAMP_W])
    );
  end

  assign dim_en_o   = en;
  assign switch_o   = switch_req_i & en;
  assign disc_o     = en;
  assign amp_hold_o = ~en;
endmodule

// File: rtl/dim_mode_sel_chk.sv
module dim_mode_sel_chk
  import dim_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int RAMP_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  wrap_stb,
  input logic [RAMP_W-1:0]     ramp,
  input dim_mode_t             mode_q,
  input logic [NCH*RAMP_W-1:0] lvl_cur,
  input logic [NCH-1:0]        switch_req_i,
  input logic [NCH-1:0]        dim_en_o,
  input logic [NCH-1:0]        switch_o,
  input logic [NCH-1:0]        disc_o,
  input logic [NCH-1:0]        amp_hold_o
);
  localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_off: assert (dim_en_o == '0 && switch_o == '0 && amp_hold_o == {NCH{1'b1}});
    end
  end

  a_r3_ramp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ramp));

  a_r3_ramp_steps: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ramp == $past(ramp) + 1'b1));

  a_r7_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_stb |=> $stable(lvl_cur));

  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_stb |=> $stable(mode_q));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r4_full_on: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.ramp && mode_q.rising && lvl_cur[c*RAMP_W +: RAMP_W] == FULL) |=> dim_en_o[c]);

    a_r5_zero_on: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.ramp && !mode_q.rising && lvl_cur[c*RAMP_W +: RAMP_W] == '0) |=> dim_en_o[c]);

    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !dim_en_o[c] |-> (!switch_o[c] && !disc_o[c] && amp_hold_o[c]));

    a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (dim_en_o[c] && switch_req_i[c]) |-> (switch_o[c] && disc_o[c] && !amp_hold_o[c]));
  end
endmodule

bind dim_mode_sel dim_mode_sel_chk #(.NCH(NCH), .RAMP_W(RAMP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap_stb(wrap_stb), .ramp(ramp),
  .mode_q(mode_q), .lvl_cur(lvl_cur), .switch_req_i(switch_req_i),
  .dim_en_o(dim_en_o), .switch_o(switch_o), .disc_o(disc_o), .amp_hold_o(amp_hold_o)
);

// File: tb/dim_mode_sel_tb_top.sv
module dim_mode_sel_tb_top;
  localparam int NCH    = 3;
  localparam int RAMP_W = 8;
  localparam int PRE_W  = 8;
  localparam int STEPS  = 1 << RAMP_W;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  ramp_mode_i;
  logic                  rising_i;
  logic [PRE_W-1:0]      prescale_i;
  logic [NCH-1:0]        direct_dim_i;
  logic [NCH*RAMP_W-1:0] level_i;
  logic [NCH-1:0]        switch_req_i;
  logic [NCH-1:0]        dim_en_o, switch_o, disc_o, amp_hold_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int    ch;
    int    exp;
    string req;
  } exp_t;
  exp_t sb_q[$];

  bit meas_go   = 0;
  bit meas_done = 0;
  int meas_len  = 0;

  always #5 clk = ~clk;

  dim_mode_sel #(.NCH(NCH), .RAMP_W(RAMP_W), .PRE_W(PRE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ramp_mode_i(ramp_mode_i), .rising_i(rising_i),
    .prescale_i(prescale_i), .direct_dim_i(direct_dim_i), .level_i(level_i),
    .switch_req_i(switch_req_i), .dim_en_o(dim_en_o), .switch_o(switch_o),
    .disc_o(disc_o), .amp_hold_o(amp_hold_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic set_levels(int l0, int l1, int l2);
    level_i = {l2[RAMP_W-1:0], l1[RAMP_W-1:0], l0[RAMP_W-1:0]};
  endtask

  task automatic expect_duty(int ch, int exp, string req);
    exp_t e;
    e.ch = ch; e.exp = exp; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(int len);
    meas_len  = len;
    meas_done = 0;
    meas_go   = 1;
    wait (meas_done);
  endtask

  // monitor: counts enabled cycles per channel and compares with the queue
  initial begin
    forever begin
      int cnt [NCH];
      wait (meas_go);
      for (int c = 0; c < NCH; c++) cnt[c] = 0;
      for (int i = 0; i < meas_len; i++) begin
        @(negedge clk);
        for (int c = 0; c < NCH; c++) if (dim_en_o[c]) cnt[c]++;
      end
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, cnt[e.ch], e.exp);
      end
      meas_go   = 0;
      meas_done = 1;
    end
  end

  initial begin
    #(1_500_000ns);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic wait_rise0();
    bit prev;
    prev = dim_en_o[0];
    forever begin
      @(negedge clk);
      if (dim_en_o[0] && !prev) break;
      prev = dim_en_o[0];
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ramp_mode_i = 1'b0; rising_i = 1'b0; prescale_i = '0;
    direct_dim_i = '0; switch_req_i = '0; level_i = '0;
    wait_neg(3);
    // R1: outputs during reset
    check("R1 en in reset", int'(dim_en_o), 0);
    check("R1 hold in reset", int'(amp_hold_o), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 disc after reset", int'(disc_o), 0);
    check("R1 switch after reset", int'(switch_o), 0);

    // R2: direct mode latency
    switch_req_i = 3'b111;
    direct_dim_i = 3'b101;
    wait_neg(2);
    check("R2 not yet after 2 edges", int'(dim_en_o), 0);
    wait_neg(1);
    check("R2 follows after 3 edges", int'(dim_en_o), 5);
    // R9: gating
    check("R9 switch gated", int'(switch_o), 5);
    check("R9 disc follows", int'(disc_o), 5);
    check("R9 hold inverse", int'(amp_hold_o), 2);
    switch_req_i = 3'b001;
    @(negedge clk);
    check("R9 switch req masked", int'(switch_o), 1);
    // R2: polarity irrelevant in direct mode
    rising_i = 1'b1;
    wait_neg(600);
    direct_dim_i = 3'b010;
    wait_neg(3);
    check("R2 rising polarity direct", int'(dim_en_o), 2);
    switch_req_i = 3'b111;

    // R4 R6: rising ramp
    ramp_mode_i = 1'b1;
    set_levels(0, 128, 255);
    wait_neg(2 * STEPS + 20);
    expect_duty(0, 0, "R4 level 0 rising");
    expect_duty(1, 128, "R6 level 128 rising");
    expect_duty(2, STEPS, "R4 full scale rising");
    measure(STEPS);
    set_levels(1, 64, 254);
    wait_neg(2 * STEPS + 20);
    expect_duty(0, 1, "R4 level 1 rising");
    expect_duty(1, 64, "R6 level 64 rising");
    expect_duty(2, 254, "R4 level 254 rising");
    measure(STEPS);

    // R5: falling ramp
    rising_i = 1'b0;
    set_levels(0, 128, 255);
    wait_neg(2 * STEPS + 20);
    expect_duty(0, STEPS, "R5 level 0 falling");
    expect_duty(1, 127, "R5 level 128 falling");
    expect_duty(2, 0, "R5 full scale falling");
    measure(STEPS);
    set_levels(200, 1, 254);
    wait_neg(2 * STEPS + 20);
    expect_duty(0, 55, "R5 level 200 falling");
    expect_duty(1, 254, "R5 level 1 falling");
    expect_duty(2, 1, "R5 level 254 falling");
    measure(STEPS);

    // R3: prescaler stretches the period
    rising_i = 1'b1;
    prescale_i = 8'd2;
    set_levels(128, 10, 255);
    wait_neg(2 * 3 * STEPS + 20);
    expect_duty(0, 3 * 128, "R3 prescale 2 level 128");
    expect_duty(1, 3 * 10, "R3 prescale 2 level 10");
    expect_duty(2, 3 * STEPS, "R3 prescale 2 full scale");
    measure(3 * STEPS);
    prescale_i = '0;

    // R7: level change inside a period waits for the wrap
    set_levels(128, 128, 128);
    wait_neg(2 * 3 * STEPS + 20);
    wait_rise0();
    begin
      int hi;
      hi = 1;
      for (int k = 1; k < STEPS; k++) begin
        if (k == 10) set_levels(255, 128, 128);
        @(negedge clk);
        if (dim_en_o[0]) hi++;
      end
      check("R7 level held until wrap", hi, 128);
    end
    wait_neg(2 * STEPS);
    check("R7 new level applied after wrap", int'(dim_en_o[0]), 1);

    // R8: mode change inside a period waits for the wrap
    set_levels(128, 128, 128);
    direct_dim_i = 3'b111;
    wait_neg(2 * STEPS + 20);
    wait_rise0();
    wait_neg(20);
    ramp_mode_i = 1'b0;
    wait_neg(120);
    check("R8 ramp mode kept until wrap", int'(dim_en_o[0]), 0);
    wait_neg(120);
    check("R8 direct mode after wrap", int'(dim_en_o[0]), 1);

    finish_run();
  end
endmodule